// File: doc/BRIEF.md
# GPIO External Interrupt Controller

This block turns up to 32 GPIO pins into interrupt sources. Each line has its own trigger mode: rising edge, falling edge, both edges, high level or low level. A detected trigger latches into a per-line pending bit. An enable mask selects which pending bits reach the one combined interrupt output that goes to the parent interrupt controller.

A line is only observed while its pin is muxed to the interrupt function. The multiplexer reports this on a per-line qualifier input. Pin inputs are synchronised into the block clock before any edge is detected.

Software uses a simple 32-bit register bus with single-cycle writes and combinational reads. It programs the modes and the mask. On an interrupt it reads the pending word, then writes the bits it found back as ones to clear them.

Top module: `gpio_xint_ctrl`

## Requirements
- R1: After reset the config words, the enable word and the pending word all read as zero, and `irq_out` is low.
- R2: Line n's 4-bit mode field sits in the config word at byte offset 0x200 + 4*(n/8), at bits (n mod 8)*4 +: 4. The four config words are at 0x200, 0x204, 0x208 and 0x20C, and each reads back exactly what was written.
- R3: With mode 0 (rising edge), a low-to-high transition of the synchronised pin sets the line's pending bit. A high-to-low transition does not.
- R4: With mode 1 (falling edge), a high-to-low transition sets the pending bit. A low-to-high transition does not.
- R5: With mode 4 (both edges), either transition sets the pending bit.
- R6: With mode 2 (high level) or mode 3 (low level), the pending bit is set on every cycle the level is active. When a set and a write-1 clear fall in the same cycle, the bit stays set.
- R7: The pending word is at offset 0x214. Writing 1 to a bit clears it when no trigger is active, and writing 0 leaves the bit unchanged.
- R8: Pending bits are set whether or not the line is enabled. The enable word is at offset 0x210 and reads back as written. `irq_out` is high exactly when some line has both its pending bit and its enable bit set.
- R9: While a line's `func_irq` bit is low, nothing on its pin sets its pending bit.
- R10: Mode values 5 to 15 never set a pending bit.
- R11: A pin change driven before clock edge k shows in the pending word after edge k+2 and not after edge k+1: two synchroniser edges and one latch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier; a write occurs when both `bus_en` and `bus_we` are high |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NLINES | Raw pin levels, asynchronous to `clk` |
| func_irq | input | NLINES | High while the pin is muxed to the interrupt function |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
A wrong internal state shows at the ports within three clock edges of a pin change. It appears as a pending bit that is missing, spurious or late, and the latency check counts those edges exactly. A mis-decoded mode field or a misplaced config nibble shows up as the wrong line or the wrong polarity raising its bit. A broken clear, or a clear that wins over the set, shows in the very next read of the pending word. A fault in the mask shows on `irq_out` on the cycle after the enable write.

// File: rtl/xint_pkg.sv
package xint_pkg;

    localparam int unsigned MODE_W        = 4;
    localparam int unsigned LINES_PER_CFG = 8;
    localparam int unsigned CFG_BASE      = 32'h200;
    localparam int unsigned EN_OFS        = 32'h210;
    localparam int unsigned ST_OFS        = 32'h214;

    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_mode_e;

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/xint_trig_detect.sv
module xint_trig_detect
    import xint_pkg::*;
#(
    parameter int unsigned NLINES = 32
) (
    input  logic [NLINES-1:0]        cur,
    input  logic [NLINES-1:0]        prev,
    input  logic [NLINES-1:0]        func,
    input  logic [NLINES*MODE_W-1:0] cfg,
    output logic [NLINES-1:0]        hit
);

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        logic raw;
        always_comb begin
            unique case (cfg[n*MODE_W +: MODE_W])
                TRIG_RISE: raw = cur[n] & ~prev[n];
                TRIG_FALL: raw = ~cur[n] & prev[n];
                TRIG_HIGH: raw = cur[n];
                TRIG_LOW:  raw = ~cur[n];
                TRIG_BOTH: raw = cur[n] ^ prev[n];
                default:   raw = 1'b0;
            endcase
        end
        assign hit[n] = raw & func[n];
    end

endmodule

// File: rtl/gpio_xint_ctrl.sv
module gpio_xint_ctrl
    import xint_pkg::*;
#(
    parameter int unsigned NLINES      = 32,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    input  logic [NLINES-1:0] func_irq,
    output logic              irq_out
);

    localparam int unsigned CFG_WORDS = (NLINES + LINES_PER_CFG - 1) / LINES_PER_CFG;
    localparam int unsigned WIDX_W    = ADDR_W - 2;

    typedef struct packed {
        logic [NLINES*MODE_W-1:0] cfg;
        logic [NLINES-1:0]        en;
        logic [NLINES-1:0]        st;
        logic [NLINES-1:0]        prev;
    } state_t;

    state_t state_d, state_q;

    logic [NLINES-1:0] sync_s;
    logic [NLINES-1:0] hit;
    logic [NLINES-1:0] st_q, en_q;
    logic [WIDX_W-1:0] word_idx;
    logic              wr, cfg_sel, en_sel, st_sel;

    xint_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_s)
    );

    xint_trig_detect #(.NLINES(NLINES)) det_i (
        .cur   (sync_s),
        .prev  (state_q.prev),
        .func  (func_irq),
        .cfg   (state_q.cfg),
        .hit   (hit)
    );

    assign st_q     = state_q.st;
    assign en_q     = state_q.en;
    assign wr       = bus_en & bus_we;
    assign word_idx = bus_addr[ADDR_W-1:2] - WIDX_W'(CFG_BASE >> 2);
    assign cfg_sel  = (bus_addr >= ADDR_W'(CFG_BASE)) && (word_idx < WIDX_W'(CFG_WORDS))
                      && (bus_addr[1:0] == 2'b00);
    assign en_sel   = (bus_addr == ADDR_W'(EN_OFS));
    assign st_sel   = (bus_addr == ADDR_W'(ST_OFS));

    // next-state process
    always_comb begin
        logic [NLINES-1:0] clr;
        state_d      = state_q;
        state_d.prev = sync_s;
        clr          = (wr && st_sel) ? bus_wdata[NLINES-1:0] : '0;
        if (wr && cfg_sel) begin
            for (int j = 0; j < NLINES; j++) begin
                if (word_idx == WIDX_W'(j / LINES_PER_CFG))
                    state_d.cfg[j*MODE_W +: MODE_W] =
                        bus_wdata[(j % LINES_PER_CFG)*MODE_W +: MODE_W];
            end
        end
        if (wr && en_sel) state_d.en = bus_wdata[NLINES-1:0];
        // detection wins over a same-cycle clear
        state_d.st = (state_q.st & ~clr) | hit;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (cfg_sel) begin
            for (int j = 0; j < NLINES; j++) begin
                if (word_idx == WIDX_W'(j / LINES_PER_CFG))
                    bus_rdata[(j % LINES_PER_CFG)*MODE_W +: MODE_W] =
                        state_q.cfg[j*MODE_W +: MODE_W];
            end
        end else if (en_sel) begin
            bus_rdata[NLINES-1:0] = state_q.en;
        end else if (st_sel) begin
            bus_rdata[NLINES-1:0] = state_q.st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq_out = |(state_q.st & state_q.en);

endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
    import xint_pkg::*;
#(
    parameter int unsigned NLINES = 32,
    parameter int unsigned ADDR_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_en,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [31:0]              bus_wdata,
    input logic [NLINES-1:0]        st_q,
    input logic [NLINES-1:0]        en_q,
    input logic [NLINES-1:0]        hit,
    input logic [NLINES-1:0]        func_irq,
    input logic [NLINES*MODE_W-1:0] cfg,
    input logic                     irq_out
);

    logic st_wr;
    assign st_wr = bus_en && bus_we && (bus_addr == ADDR_W'(ST_OFS));

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out); // R8

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((st_q & en_q) != '0)); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((st_q & $past(bus_wdata[NLINES-1:0]) & ~$past(hit)) == '0)); // R7

    AST_SET_ONLY_BY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(hit)) == '0)); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((st_q & $past(hit)) == $past(hit))); // R6

    AST_FUNC_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & ~func_irq) == '0)); // R9

    always @(posedge clk) begin
        if (rst_n) begin
            for (int n = 0; n < NLINES; n++) begin
                AST_RESERVED_QUIET: assert (!(cfg[n*MODE_W +: MODE_W] > 4'd4 && hit[n])); // R10
            end
        end
    end

endmodule

bind gpio_xint_ctrl xint_ctrl_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .st_q      (st_q),
    .en_q      (en_q),
    .hit       (hit),
    .func_irq  (func_irq),
    .cfg       (state_q.cfg),
    .irq_out   (irq_out)
);

// File: tb/gpio_xint_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_xint_ctrl_tb_top;

    localparam int NL = 32;
    localparam logic [11:0] A_CFG0 = 12'h200, A_CFG1 = 12'h204, A_CFG2 = 12'h208,
                            A_CFG3 = 12'h20C, A_EN = 12'h210, A_ST = 12'h214;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NL-1:0] pin_in = 32'h0000_0800;
    logic [NL-1:0] func_irq = '0;
    logic irq_out;

    always #4 clk = ~clk;

    gpio_xint_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .func_irq(func_irq), .irq_out(irq_out)
    );

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    event  smp_ev;
    int    n_tests = 0, n_fail = 0;
    bit    done = 1'b0;

    // monitor: pops the expected item and compares with the port value
    always @(smp_ev) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
        n_tests++;
        if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
    end

    task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        sb_q.push_back('{tag, 1'b0, e});
        bus_addr = a;
        #1 -> smp_ev;
        #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        sb_q.push_back('{tag, 1'b1, {31'b0, e}});
        #1 -> smp_ev;
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        #2;
    endtask

    task automatic set_pin(input int i, input logic v);
        @(negedge clk);
        pin_in[i] = v;
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        settle();

        // R1 reset state
        chk_rd(A_CFG0, 32'h0, "R1 cfg0");
        chk_rd(A_CFG3, 32'h0, "R1 cfg3");
        chk_rd(A_EN,   32'h0, "R1 enable");
        chk_rd(A_ST,   32'h0, "R1 pending");
        chk_irq(1'b0, "R1 irq_out");

        // R2 layout: line8 rise, 9 fall, 10 high, 11 low, 12 both; line31 reserved 15
        wr(A_CFG1, 32'h0004_3210);
        wr(A_CFG3, 32'hF000_0000);
        wr(A_CFG2, 32'h0000_0000);
        chk_rd(A_CFG1, 32'h0004_3210, "R2 cfg word 0x204");
        chk_rd(A_CFG3, 32'hF000_0000, "R2 cfg word 0x20C");
        chk_rd(A_CFG0, 32'h0, "R2 cfg word 0x200 untouched");
        wr(A_ST, 32'hFFFF_FFFF);
        @(negedge clk); func_irq = '1;
        settle();
        chk_rd(A_ST, 32'h0, "R1 nothing pending after enabling function");

        // R11 latency, R3 rising
        @(negedge clk); pin_in[8] = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        chk_rd(A_ST, 32'h0, "R11 not yet after two edges");
        @(posedge clk); #2;
        chk_rd(A_ST, 32'h0000_0100, "R11 R3 set after third edge");
        wr(A_ST, 32'h0000_0100);
        chk_rd(A_ST, 32'h0, "R7 clear rising line");
        set_pin(8, 1'b0);
        chk_rd(A_ST, 32'h0, "R3 falling edge ignored in rising mode");

        // R4 falling
        set_pin(9, 1'b1);
        chk_rd(A_ST, 32'h0, "R4 rising edge ignored in falling mode");
        set_pin(9, 1'b0);
        chk_rd(A_ST, 32'h0000_0200, "R4 falling edge sets");

        // R7: second pending line, write 1 to one bit only
        set_pin(8, 1'b1);
        chk_rd(A_ST, 32'h0000_0300, "R7 two lines pending");
        wr(A_ST, 32'h0000_0100);
        chk_rd(A_ST, 32'h0000_0200, "R7 zero bits leave pending unchanged");

        // R8 mask and combined output
        chk_irq(1'b0, "R8 pending but masked");
        wr(A_EN, 32'h0000_0200);
        chk_rd(A_EN, 32'h0000_0200, "R8 enable readback");
        chk_irq(1'b1, "R8 enabled pending drives irq");
        wr(A_EN, 32'h0000_0100);
        chk_irq(1'b0, "R8 other line enabled only");
        wr(A_ST, 32'h0000_0200);
        wr(A_EN, 32'h0);

        // R5 both edges
        set_pin(12, 1'b1);
        chk_rd(A_ST, 32'h0000_1000, "R5 rise sets");
        wr(A_ST, 32'h0000_1000);
        set_pin(12, 1'b0);
        chk_rd(A_ST, 32'h0000_1000, "R5 fall sets");
        wr(A_ST, 32'h0000_1000);

        // R6 high level
        set_pin(10, 1'b1);
        chk_rd(A_ST, 32'h0000_0400, "R6 high level sets");
        wr(A_ST, 32'h0000_0400);
        chk_rd(A_ST, 32'h0000_0400, "R6 high level re-sets over clear");
        set_pin(10, 1'b0);
        wr(A_ST, 32'h0000_0400);
        chk_rd(A_ST, 32'h0, "R6 clear once high level gone");

        // R6 low level
        set_pin(11, 1'b0);
        chk_rd(A_ST, 32'h0000_0800, "R6 low level sets");
        wr(A_ST, 32'h0000_0800);
        chk_rd(A_ST, 32'h0000_0800, "R6 low level re-sets over clear");
        set_pin(11, 1'b1);
        wr(A_ST, 32'h0000_0800);
        chk_rd(A_ST, 32'h0, "R6 clear once low level gone");

        // R9 function gating (line 8 is high, rising mode)
        @(negedge clk); func_irq[8] = 1'b0;
        set_pin(8, 1'b0);
        set_pin(8, 1'b1);
        chk_rd(A_ST, 32'h0, "R9 edge ignored without interrupt function");
        chk_irq(1'b0, "R9 irq stays low");
        @(negedge clk); func_irq[8] = 1'b1;

        // R10 reserved mode
        set_pin(31, 1'b1);
        set_pin(31, 1'b0);
        chk_rd(A_ST, 32'h0, "R10 reserved mode never pends");

        done = 1'b1;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard R1 actual=%0d expected=0 items left", sb_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R11 actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule